// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic unit for an 8-bit datapath. Each operation arrives on a valid/ready input stream as a 4-bit operation code plus two operand bytes. The block first latches the operation into a hidden staging register that holds the first and second operand. One stage later it writes the result byte and a status byte into an output register, which drives a valid/ready output stream.

The status byte reports four conditions:

| Bit | Condition |
|-----|-----------|
| 0 | zero |
| 1 | negative |
| 2 | carry or borrow |
| 3 | overflow |

Bits 7 to 4 are reserved and always read 0. The status byte stays valid after the result has been taken, so that sequencing logic elsewhere, such as conditional branches, can test it until the next operation completes.

Back-pressure rules for the two streams:
- An input beat transfers on a clock edge where `in_valid` and `in_ready` are both high.
- An output beat transfers on a clock edge where `out_valid` and `out_ready` are both high.
- A beat offered on `out_valid` keeps its contents until it is taken.
- `in_ready` falls only while both the staging register and the output register hold data and the output cannot drain.

Top module: `byte_alu`

## Requirements
- R1: An input beat accepted at clock edge k, with the output register free, appears on `out_valid` after edge k+1. Results leave in the order the operations were accepted.
- R2: While `out_valid` is high and `out_ready` is low, `out_result` and `out_flags` stay unchanged. `in_ready` is low only in cycles where `out_valid` is high and `out_ready` is low.
- R3: Code 0x4 gives A+B. Flag bit 2 is the carry-out, and flag bit 3 is set when A and B have the same sign and the result has the other sign. Code 0x5 gives A-B. Flag bit 2 is set when A<B unsigned (borrow), and flag bit 3 is set when A and B have different signs and the result's sign differs from A's.
- R4: Code 0x6 gives the low byte of A*B. Flag bit 3 is set when the product exceeds 0xFF, and flag bit 2 is 0.
- R5: Code 0x7 gives the unsigned quotient A/B with flag bits 2 and 3 clear. When B is 0 the result is 0xFF and flag bit 3 is set.
- R6: Code 0x8 gives A shifted left by B, and code 0x9 gives A shifted right logically by B. A shift amount B of 8 or more gives 0x00. Flag bits 2 and 3 are 0.
- R7: Code 0xA gives the inverse of A, and B has no effect on the result. Code 0xB gives A AND B, 0xC gives A XOR B, and 0xD gives A OR B. Flag bits 2 and 3 are 0.
- R8: Flag bit 0 is 1 exactly when the result is 0x00, and flag bit 1 equals result bit 7. Flag bits 7 to 4 are always 0.
- R9: Codes 0x0 to 0x3, 0xE and 0xF give a result of 0x00 with flags 0x01.
- R10: After reset, `out_valid` is 0, `out_result` is 0x00, `out_flags` is 0x00 and `in_ready` is 1. Once a result has been taken, `out_flags` keeps its value until the next result is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_op | input | 4 | Operation code |
| in_a | input | 8 | First operand (A) |
| in_b | input | 8 | Second operand (B) |
| out_valid | output | 1 | Result beat offered |
| out_ready | input | 1 | Consumer takes the result beat |
| out_result | output | 8 | Result byte |
| out_flags | output | 8 | Status byte: bit0 zero, bit1 negative, bit2 carry/borrow, bit3 overflow, bits 7-4 zero |

## Verification
The hardest situation to reach from the ports is a full pipeline: the output register stalled with an unusual result (divide by zero, a shift of exactly 8, a product of exactly 0x100) while a second operation waits in staging and a third is held at the input. The bench reaches it by randomly dropping `out_ready` for about a third of the cycles and keeping the input busy. The directed corner operations therefore meet stalls at varying depths.

Each stalled cycle is compared with the cycle before it. Each delivered beat is matched against a reference model in order.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int DATA_W  = 8;
  localparam int OP_W    = 4;
  localparam int FLAGS_W = 8;

  localparam int FLAG_ZERO  = 0;
  localparam int FLAG_NEG   = 1;
  localparam int FLAG_CARRY = 2;
  localparam int FLAG_OVF   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'h4,
    OP_SUB = 4'h5,
    OP_MUL = 4'h6,
    OP_DIV = 4'h7,
    OP_SHL = 4'h8,
    OP_SHR = 4'h9,
    OP_INV = 4'hA,
    OP_AND = 4'hB,
    OP_XOR = 4'hC,
    OP_OR  = 4'hD
  } alu_op_e;
endpackage

// File: rtl/byte_alu_arith.sv
module byte_alu_arith
  import byte_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic            hit,
  output logic [W-1:0]    res,
  output logic            carry,
  output logic            ovf
);
  localparam int PW = 2 * W;

  logic [W:0]    sum_x;
  logic [W:0]    dif_x;
  logic [PW-1:0] prod;

  assign sum_x = {1'b0, a} + {1'b0, b};
  assign dif_x = {1'b0, a} - {1'b0, b};
  assign prod  = PW'(a) * PW'(b);

  always_comb begin
    hit   = 1'b1;
    res   = '0;
    carry = 1'b0;
    ovf   = 1'b0;
    unique case (op)
      OP_ADD: begin
        res   = sum_x[W-1:0];
        carry = sum_x[W];
        ovf   = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
      end
      OP_SUB: begin
        res   = dif_x[W-1:0];
        carry = dif_x[W];
        ovf   = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
      end
      OP_MUL: begin
        res = prod[W-1:0];
        ovf = |prod[PW-1:W];
      end
      OP_DIV: begin
        if (b == '0) begin
          res = '1;
          ovf = 1'b1;
        end else begin
          res = a / b;
        end
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/byte_alu_bitwise.sv
module byte_alu_bitwise
  import byte_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic            hit,
  output logic [W-1:0]    res
);
  localparam logic [W-1:0] SHIFT_LIM = W[W-1:0];

  logic out_of_range;
  assign out_of_range = (b >= SHIFT_LIM);

  always_comb begin
    hit = 1'b1;
    res = '0;
    unique case (op)
      OP_SHL:  res = out_of_range ? '0 : (a << b);
      OP_SHR:  res = out_of_range ? '0 : (a >> b);
      OP_INV:  res = ~a;
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      OP_OR:   res = a | b;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/byte_alu_flagpack.sv
module byte_alu_flagpack
  import byte_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0]       res,
  input  logic               carry,
  input  logic               ovf,
  output logic [FLAGS_W-1:0] flags
);
  localparam int USED = 4;

  assign flags[FLAG_ZERO]  = (res == '0);
  assign flags[FLAG_NEG]   = res[W-1];
  assign flags[FLAG_CARRY] = carry;
  assign flags[FLAG_OVF]   = ovf;

  for (genvar i = USED; i < FLAGS_W; i++) begin : g_rsvd
    assign flags[i] = 1'b0;
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [OP_W-1:0]    in_op,
  input  logic [W-1:0]       in_a,
  input  logic [W-1:0]       in_b,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [W-1:0]       out_result,
  output logic [FLAGS_W-1:0] out_flags
);
  // staging: hidden operand registers
  logic            stg_valid;
  logic [OP_W-1:0] stg_op;
  logic [W-1:0]    tmp_a;
  logic [W-1:0]    tmp_b;

  logic out_free, stg_free, stg_load, out_load;

  assign out_free = !out_valid || out_ready;
  assign stg_free = !stg_valid || out_free;
  assign in_ready = stg_free;
  assign stg_load = in_valid && stg_free;
  assign out_load = stg_valid && out_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_valid <= 1'b0;
      stg_op    <= '0;
      tmp_a     <= '0;
      tmp_b     <= '0;
    end else begin
      if (stg_free) stg_valid <= in_valid;
      if (stg_load) begin
        stg_op <= in_op;
        tmp_a  <= in_a;
        tmp_b  <= in_b;
      end
    end
  end

  logic         ar_hit, ar_c, ar_v, bw_hit;
  logic [W-1:0] ar_res, bw_res, sel_res;
  logic         sel_c, sel_v;
  logic [FLAGS_W-1:0] sel_flags;

  byte_alu_arith #(.W(W)) u_arith (
    .op(stg_op), .a(tmp_a), .b(tmp_b),
    .hit(ar_hit), .res(ar_res), .carry(ar_c), .ovf(ar_v)
  );

  byte_alu_bitwise #(.W(W)) u_bitwise (
    .op(stg_op), .a(tmp_a), .b(tmp_b),
    .hit(bw_hit), .res(bw_res)
  );

  always_comb begin
    sel_res = '0;
    sel_c   = 1'b0;
    sel_v   = 1'b0;
    if (ar_hit) begin
      sel_res = ar_res;
      sel_c   = ar_c;
      sel_v   = ar_v;
    end else if (bw_hit) begin
      sel_res = bw_res;
    end
  end

  byte_alu_flagpack #(.W(W)) u_flags (
    .res(sel_res), .carry(sel_c), .ovf(sel_v), .flags(sel_flags)
  );

  // output register; flags persist after the beat is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
    end else begin
      if (out_free) out_valid <= stg_valid;
      if (out_load) begin
        out_result <= sel_res;
        out_flags  <= sel_flags;
      end
    end
  end
endmodule

// File: rtl/byte_alu_sva.sv
module byte_alu_sva
  import byte_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [W-1:0]       out_result,
  input logic [FLAGS_W-1:0] out_flags
);
  p_hold_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)));

  p_ready_only_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[FLAG_ZERO] == (out_result == '0)));

  p_neg_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[FLAG_NEG] == out_result[W-1]));

  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_flags[FLAGS_W-1:4] == '0);

  p_flags_persist_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> (out_valid || $stable(out_flags)));

  p_fill_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !out_valid) |=> ##1 out_valid);
endmodule

bind byte_alu byte_alu_sva #(.W(W)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_flags(out_flags)
);

// File: tb/tb_byte_alu.sv
module tb_byte_alu;
  localparam int TOTAL  = 600;
  localparam int NDIR   = 18;
  localparam int LIMIT  = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_result;
  logic [7:0] out_flags;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  byte_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags)
  );

  // reference model: {flags, result}
  function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b);
    logic [7:0] r; logic c, v; int t;
    r = 8'h00; c = 0; v = 0;
    case (op)
      4'h4: begin t = int'(a) + int'(b); r = t[7:0]; c = (t > 255);
              v = (a[7] == b[7]) && (r[7] != a[7]); end
      4'h5: begin t = int'(a) - int'(b); r = t[7:0]; c = (a < b);
              v = (a[7] != b[7]) && (r[7] != a[7]); end
      4'h6: begin t = int'(a) * int'(b); r = t[7:0]; v = (t > 255); end
      4'h7: if (b == 0) begin r = 8'hFF; v = 1; end else r = a / b;
      4'h8: begin t = (b > 7) ? 0 : (int'(a) * (1 << b)); r = t[7:0]; end
      4'h9: r = (b > 7) ? 8'h00 : (a >> b);
      4'hA: r = ~a;
      4'hB: r = a & b;
      4'hC: r = a ^ b;
      4'hD: r = a | b;
      default: r = 8'h00;
    endcase
    return {4'h0, v, c, r[7], (r == 0), r};
  endfunction

  function automatic logic [19:0] directed(input int i);
    case (i)
      0:  return {4'h4, 8'h7F, 8'h01};
      1:  return {4'h4, 8'hFF, 8'h01};
      2:  return {4'h5, 8'h00, 8'h01};
      3:  return {4'h5, 8'h80, 8'h01};
      4:  return {4'h6, 8'h10, 8'h10};
      5:  return {4'h6, 8'h0F, 8'h11};
      6:  return {4'h7, 8'h07, 8'h00};
      7:  return {4'h7, 8'hC8, 8'h07};
      8:  return {4'h8, 8'h01, 8'h07};
      9:  return {4'h8, 8'h01, 8'h08};
      10: return {4'h9, 8'h80, 8'h09};
      11: return {4'hA, 8'hFF, 8'h12};
      12: return {4'hA, 8'h3C, 8'hFF};
      13: return {4'hB, 8'hF0, 8'h3C};
      14: return {4'hC, 8'hAA, 8'hAA};
      15: return {4'hD, 8'h80, 8'h01};
      16: return {4'h2, 8'h55, 8'h66};
      default: return {4'hF, 8'hFF, 8'hFF};
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h4, 4'h5: return "R3";
      4'h6: return "R4";
      4'h7: return "R5";
      4'h8, 4'h9: return "R6";
      4'hA, 4'hB, 4'hC, 4'hD: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [15:0] exp_q [TOTAL];
  logic [3:0]  op_q  [TOTAL];
  int wr = 0, rd = 0, sent = 0;
  bit held = 0;
  bit stalled = 0;
  logic [7:0] st_res, st_flg;
  logic [15:0] last_exp = '0;
  int acc_cycle = -1;
  int cyc = 0;

  initial begin
    logic [19:0] d;
    void'($urandom(32'hA1B2_C3D4));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10 reset", {out_valid, in_ready, out_result, out_flags}, {1'b0, 1'b1, 8'h00, 8'h00});
    rst_n = 1'b1;

    // R1 latency: single op into an empty pipe, consumer ready
    @(negedge clk);
    in_valid = 1; in_op = 4'h4; in_a = 8'h12; in_b = 8'h34; out_ready = 1;
    @(negedge clk); in_valid = 0;
    check("R1 not yet", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R1 latency", {out_valid, out_result, out_flags}, {1'b1, 8'h46, 8'h00});
    @(negedge clk);

    while (rd < TOTAL && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      if (stalled) begin
        check("R2 hold", {out_valid, out_result, out_flags}, {1'b1, st_res, st_flg});
      end
      if (!held) begin
        if (sent < TOTAL && ($urandom % 4) != 0) begin
          if (sent < NDIR) d = directed(sent);
          else begin
            d[19:16] = 4'($urandom % 16);
            d[15:8]  = 8'($urandom);
            d[7:0]   = (($urandom % 3) == 0) ? 8'($urandom % 12) : 8'($urandom);
          end
          in_op = d[19:16]; in_a = d[15:8]; in_b = d[7:0];
          in_valid = 1;
        end else in_valid = 0;
      end
      out_ready = ($urandom % 3) != 0;
      #1;
      if (!in_ready) check("R2 ready", {out_valid, out_ready}, {1'b1, 1'b0});
      stalled = out_valid && !out_ready;
      st_res = out_result; st_flg = out_flags;
      if (out_valid && out_ready) begin
        check(req_of(op_q[rd]), {out_result, out_flags}, {exp_q[rd][7:0], exp_q[rd][15:8]});
        if (exp_q[rd][15:8] == 8'h00 || out_flags[7:4] != 0)
          check("R8 rsvd", {28'd0, out_flags[7:4]}, 32'd0);
        last_exp = exp_q[rd];
        rd++;
      end
      if (in_valid && in_ready) begin
        exp_q[wr] = model(in_op, in_a, in_b);
        op_q[wr] = in_op;
        wr++; sent++; held = 0;
      end else held = in_valid;
    end
    in_valid = 0;
    out_ready = 1;
    repeat (4) @(negedge clk);
    // R10 flags persist after the last beat is taken
    check("R10 persist", {out_valid, out_flags}, {1'b0, last_exp[15:8]});
    check("R1 count", rd, TOTAL);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(4 * LIMIT + 400);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd, TOTAL);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule